// File: doc/BRIEF.md
# Out-of-Place Remap Table with Migration Buffer

This unit sits on the read-miss path of a persistent-memory controller. Every line that leaves the last-level cache inside a transaction goes to an out-of-place area instead of its home location. For each such line the unit records the pair of addresses (home line address, out-of-place address) in a hashed, set-associative table. One table serves every core.

On a read miss the unit resolves where the newest copy lives. It checks three places in a fixed order: the remap table first, then a small buffer of lines that garbage collection is moving home, and finally the home address itself. A remap hit returns the out-of-place address and drops the entry, because the line is then back in the cache hierarchy. Garbage collection can also drop an entry once the newest version has been written home. While that write is in flight, the line and its home address are held in the migration buffer, so a miss never sees stale data. The buffer releases its oldest line each time the home write is acknowledged.

Top module: `remap_evict_unit`

## Requirements
- R1: After reset, `res_valid`, `table_full` and `evb_full` are 0, and a lookup of any address reports the home source.
- R2: A lookup on `lk_valid` produces exactly one result, with `res_valid` high on the cycle after the lookup cycle. Source code 2'b01 means remap; `res_addr` is then the stored out-of-place address zero-extended, and `res_data` is 0. Code 2'b11 never appears.
- R3: A lookup that hits the remap table removes that entry, so the next lookup of the same address does not report remap.
- R4: A lookup that hits neither the table nor the migration buffer reports code 2'b00 (home), with `res_addr` equal to the looked-up address and `res_data` 0.
- R5: An insert for a home address already in the table replaces its out-of-place address in the same way, so each address has at most one entry.
- R6: The set index is `home[IDX_W-1:0] ^ home[2*IDX_W-1:IDX_W]` and each set holds WAYS entries. An insert of a new address into a set with no free way is dropped and leaves the other entries intact. `table_full` is 1 for the one cycle after that insert cycle.
- R7: A removal on `gc_valid` deletes the matching entry. A removal of an address that has no entry changes nothing.
- R8: A fill stores a line (home address and data). A lookup that misses the table but matches a stored line reports code 2'b10, with `res_addr` equal to the home address and `res_data` equal to the stored data.
- R9: When an address is in both the table and the migration buffer, the table wins. Once the table entry is gone, the buffer copy is returned.
- R10: Each `evb_ack` frees the oldest buffered line. When several buffered lines share one home address, the most recently filled one is returned.
- R11: `evb_full` is 1 while EVB_DEPTH lines are held, and a fill while full is ignored.
- R12: A lookup sees table contents as they were before any insert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Record a line moved to the out-of-place area |
| ins_home | input | HOME_W | Home line address of the insert |
| ins_oop | input | OOP_W | Out-of-place address of the insert |
| table_full | output | 1 | Previous-cycle insert was dropped for lack of a way |
| lk_valid | input | 1 | Read-miss lookup request |
| lk_home | input | HOME_W | Address being looked up |
| res_valid | output | 1 | Lookup result valid |
| res_src | output | 2 | 00 home, 01 remap, 10 migration buffer |
| res_addr | output | HOME_W | Address to read from (out-of-place or home) |
| res_data | output | DATA_W | Buffered line data on a buffer hit, else 0 |
| gc_valid | input | 1 | Remove the entry migrated home |
| gc_home | input | HOME_W | Home address whose entry is removed |
| evb_fill_valid | input | 1 | Push a line under migration |
| evb_fill_home | input | HOME_W | Home address of the pushed line |
| evb_fill_data | input | DATA_W | Data of the pushed line |
| evb_ack | input | 1 | Home write done: free the oldest line |
| evb_full | output | 1 | Migration buffer holds EVB_DEPTH lines |

## Verification
The bench fills one set with colliding addresses, including one that differs only above the hash bits. A design that hashed the wrong bits, or that took a new way for a repeated address, would either flag full too early or drop an insert too late. It then looks up an address that sits in both the table and the buffer, twice in a row. A design that probed the tiers in the wrong order, or that kept entries after a hit, would report the wrong source on one of the two lookups. Duplicate buffered lines and acknowledgements are used to expose a buffer that drains from the wrong end or returns an older copy. A fill while full followed by a drain would reveal a buffer that overwrote instead of ignoring. A lookup issued in the same cycle as an insert catches a design that forwards the new entry early.

// File: rtl/remap_evict_unit.sv
module remap_evict_unit #(
  parameter int HOME_W    = 24,
  parameter int OOP_W     = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int WAYS      = 2,
  parameter int EVB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [HOME_W-1:0] ins_home,
  input  logic [OOP_W-1:0]  ins_oop,
  output logic              table_full,
  input  logic              lk_valid,
  input  logic [HOME_W-1:0] lk_home,
  output logic              res_valid,
  output logic [1:0]        res_src,
  output logic [HOME_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_data,
  input  logic              gc_valid,
  input  logic [HOME_W-1:0] gc_home,
  input  logic              evb_fill_valid,
  input  logic [HOME_W-1:0] evb_fill_home,
  input  logic [DATA_W-1:0] evb_fill_data,
  input  logic              evb_ack,
  output logic              evb_full
);
  localparam int SETS = 1 << IDX_W;
  localparam int WP_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int EP_W = $clog2(EVB_DEPTH);
  localparam int EC_W = $clog2(EVB_DEPTH + 1);
  localparam logic [1:0] SRC_HOME  = 2'd0;
  localparam logic [1:0] SRC_REMAP = 2'd1;
  localparam logic [1:0] SRC_EVB   = 2'd2;

  function automatic logic [IDX_W-1:0] set_of(input logic [HOME_W-1:0] a);
    return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
  endfunction

  logic [WAYS-1:0]   vld [SETS];
  logic [HOME_W-1:0] tag [SETS][WAYS];
  logic [OOP_W-1:0]  oop [SETS][WAYS];

  logic [IDX_W-1:0] ins_set, lk_set, gc_set;
  assign ins_set = set_of(ins_home);
  assign lk_set  = set_of(lk_home);
  assign gc_set  = set_of(gc_home);

  logic [WAYS-1:0] ins_hit, lk_hit, gc_hit;
  logic [OOP_W-1:0] lk_oop;
  logic [WP_W-1:0] ins_way;
  logic ins_ok;

  always_comb begin
    lk_oop  = '0;
    ins_ok  = 1'b0;
    ins_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      ins_hit[w] = vld[ins_set][w] && (tag[ins_set][w] == ins_home);
      lk_hit[w]  = vld[lk_set][w]  && (tag[lk_set][w]  == lk_home);
      gc_hit[w]  = vld[gc_set][w]  && (tag[gc_set][w]  == gc_home);
      if (lk_hit[w]) lk_oop = lk_oop | oop[lk_set][w];
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[ins_set][w]) begin ins_ok = 1'b1; ins_way = WP_W'(w); end
    for (int w = 0; w < WAYS; w++)
      if (ins_hit[w]) begin ins_ok = 1'b1; ins_way = WP_W'(w); end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (lk_valid)
        for (int w = 0; w < WAYS; w++) if (lk_hit[w]) vld[lk_set][w] <= 1'b0;
      if (gc_valid)
        for (int w = 0; w < WAYS; w++) if (gc_hit[w]) vld[gc_set][w] <= 1'b0;
      if (ins_valid && ins_ok) vld[ins_set][ins_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid && ins_ok) begin
      tag[ins_set][ins_way] <= ins_home;
      oop[ins_set][ins_way] <= ins_oop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) table_full <= 1'b0;
    else        table_full <= ins_valid && !ins_ok;
  end

  logic [HOME_W-1:0] evh [EVB_DEPTH];
  logic [DATA_W-1:0] evd [EVB_DEPTH];
  logic [EP_W-1:0] rp, wp;
  logic [EC_W-1:0] cnt;
  logic push, pop, evb_hit;
  logic [DATA_W-1:0] evb_dat;

  assign evb_full = (cnt == EC_W'(EVB_DEPTH));
  assign push = evb_fill_valid && !evb_full;
  assign pop  = evb_ack && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + EC_W'(push) - EC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      evh[wp] <= evb_fill_home;
      evd[wp] <= evb_fill_data;
    end
  end

  always_comb begin
    evb_hit = 1'b0;
    evb_dat = '0;
    for (int k = 0; k < EVB_DEPTH; k++)
      if ((EC_W'(k) < cnt) && (evh[rp + EP_W'(k)] == lk_home)) begin
        evb_hit = 1'b1;
        evb_dat = evd[rp + EP_W'(k)];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_src   <= SRC_HOME;
      res_addr  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        if (|lk_hit) begin
          res_src <= SRC_REMAP; res_addr <= HOME_W'(lk_oop); res_data <= '0;
        end else if (evb_hit) begin
          res_src <= SRC_EVB;   res_addr <= lk_home;         res_data <= evb_dat;
        end else begin
          res_src <= SRC_HOME;  res_addr <= lk_home;         res_data <= '0;
        end
      end
    end
  end

  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  assert_src_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_src != 2'b11));
  assert_remap_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (|lk_hit)) |=> (res_src == SRC_REMAP));
  assert_full_needs_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    table_full |-> $past(ins_valid));
  assert_evb_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= EC_W'(EVB_DEPTH));
  assert_evb_holds_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evb_full && !evb_ack) |=> evb_full);
endmodule

// File: tb/remap_evict_unit_tb.sv
`timescale 1ns/1ps
module remap_evict_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ins_valid = 0;
  logic [23:0] ins_home = 0;
  logic [15:0] ins_oop = 0;
  logic        table_full;
  logic        lk_valid = 0;
  logic [23:0] lk_home = 0;
  logic        res_valid;
  logic [1:0]  res_src;
  logic [23:0] res_addr;
  logic [31:0] res_data;
  logic        gc_valid = 0;
  logic [23:0] gc_home = 0;
  logic        evb_fill_valid = 0;
  logic [23:0] evb_fill_home = 0;
  logic [31:0] evb_fill_data = 0;
  logic        evb_ack = 0;
  logic        evb_full;

  int total = 0, fails = 0;
  bit done = 0;
  logic [57:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  remap_evict_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_home(ins_home), .ins_oop(ins_oop), .table_full(table_full),
    .lk_valid(lk_valid), .lk_home(lk_home),
    .res_valid(res_valid), .res_src(res_src), .res_addr(res_addr), .res_data(res_data),
    .gc_valid(gc_valid), .gc_home(gc_home),
    .evb_fill_valid(evb_fill_valid), .evb_fill_home(evb_fill_home),
    .evb_fill_data(evb_fill_data), .evb_ack(evb_ack), .evb_full(evb_full)
  );

  task automatic check(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2", "unexpected result", 64'(res_valid), 64'd0);
      else begin
        logic [57:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_src, res_addr, res_data} == e, t, "lookup {src,addr,data}",
              64'({res_src, res_addr, res_data}), 64'(e));
      end
    end
  end

  task automatic lookup(input logic [23:0] h, input logic [1:0] src,
                        input logic [23:0] a, input logic [31:0] d, input string r);
    exp_q.push_back({src, a, d});
    tag_q.push_back(r);
    lk_valid = 1; lk_home = h;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic insert(input logic [23:0] h, input logic [15:0] o,
                        input bit exp_full, input string r);
    ins_valid = 1; ins_home = h; ins_oop = o;
    @(negedge clk);
    ins_valid = 0;
    check(table_full == exp_full, r, "table_full", 64'(table_full), 64'(exp_full));
  endtask

  task automatic gc_remove(input logic [23:0] h);
    gc_valid = 1; gc_home = h;
    @(negedge clk);
    gc_valid = 0;
  endtask

  task automatic fill(input logic [23:0] h, input logic [31:0] d,
                      input bit exp_full, input string r);
    evb_fill_valid = 1; evb_fill_home = h; evb_fill_data = d;
    @(negedge clk);
    evb_fill_valid = 0;
    check(evb_full == exp_full, r, "evb_full", 64'(evb_full), 64'(exp_full));
  endtask

  task automatic ack(input bit exp_full, input string r);
    evb_ack = 1;
    @(negedge clk);
    evb_ack = 0;
    check(evb_full == exp_full, r, "evb_full after ack", 64'(evb_full), 64'(exp_full));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R1", "res_valid", 64'(res_valid), 0);
    check(table_full == 0, "R1", "table_full", 64'(table_full), 0);
    check(evb_full == 0, "R1", "evb_full", 64'(evb_full), 0);
    lookup(24'h000003, 2'b00, 24'h000003, 0, "R1");
    lookup(24'h00ABCD, 2'b00, 24'h00ABCD, 0, "R4");

    insert(24'h000003, 16'h0AAA, 0, "R2");
    lookup(24'h000003, 2'b01, 24'h000AAA, 0, "R2");
    lookup(24'h000003, 2'b00, 24'h000003, 0, "R3");

    insert(24'h000011, 16'h0111, 0, "R5");
    insert(24'h000011, 16'h0222, 0, "R5");
    insert(24'h000018, 16'h0333, 0, "R5");
    insert(24'h100003, 16'h0444, 1, "R6");
    lookup(24'h000011, 2'b01, 24'h000222, 0, "R5");
    lookup(24'h000018, 2'b01, 24'h000333, 0, "R6");
    lookup(24'h100003, 2'b00, 24'h100003, 0, "R6");

    insert(24'h000021, 16'h0055, 0, "R7");
    gc_remove(24'h000021);
    lookup(24'h000021, 2'b00, 24'h000021, 0, "R7");
    insert(24'h000022, 16'h0066, 0, "R7");
    gc_remove(24'h000099);
    lookup(24'h000022, 2'b01, 24'h000066, 0, "R7");

    fill(24'h000040, 32'hD1D10001, 0, "R8");
    fill(24'h000041, 32'hD2D20002, 0, "R8");
    lookup(24'h000040, 2'b10, 24'h000040, 32'hD1D10001, "R8");
    insert(24'h000041, 16'h0077, 0, "R9");
    lookup(24'h000041, 2'b01, 24'h000077, 0, "R9");
    lookup(24'h000041, 2'b10, 24'h000041, 32'hD2D20002, "R9");

    fill(24'h000040, 32'hD3D30003, 0, "R10");
    lookup(24'h000040, 2'b10, 24'h000040, 32'hD3D30003, "R10");
    fill(24'h000050, 32'hD4D40004, 1, "R11");
    fill(24'h000060, 32'hD5D50005, 1, "R11");
    ack(0, "R11");
    lookup(24'h000040, 2'b10, 24'h000040, 32'hD3D30003, "R10");
    ack(0, "R10");
    lookup(24'h000041, 2'b00, 24'h000041, 0, "R10");
    lookup(24'h000060, 2'b00, 24'h000060, 0, "R11");
    lookup(24'h000050, 2'b10, 24'h000050, 32'hD4D40004, "R10");

    exp_q.push_back({2'b00, 24'h000070, 32'd0});
    tag_q.push_back("R12");
    ins_valid = 1; ins_home = 24'h000070; ins_oop = 16'h0088;
    lk_valid = 1; lk_home = 24'h000070;
    @(negedge clk);
    ins_valid = 0; lk_valid = 0;
    lookup(24'h000070, 2'b01, 24'h000088, 0, "R12");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "missing results", 64'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule